// File: doc/BRIEF.md
# Feistel Key Expander

This block turns a 128-bit main key into the material a four-branch block-cipher datapath needs: four 32-bit whitening words and thirty-six 32-bit round keys. A `start` pulse captures the key and launches a two-phase computation that advances one step per clock.

In the first phase the key is the data input of a twelve-round, four-branch Feistel network. Its round keys are drawn from a constant table, and the network's output is a 128-bit intermediate value L. In the second phase nine iterations each produce four round keys from L, the constants and, on alternate iterations, the main key. After each iteration L is moved through a fixed bit permutation.

The whitening words are the captured key itself. The round keys are read through a combinational read port addressed by number. A `ready` flag tells the datapath when every round key is in place. The constant table is a parameter, so an integrator supplies the values the cipher requires.

Top module: `key_expander`

## Requirements
- R1: After reset, `ready` is 0, `wk` is 0, and `rk_out` is 0 for every index.
- R2: On a clock edge where `start` is 1, `wk` takes the value of `key`, so that `wk` bits 127:96 hold whitening word 0. On every other edge `wk` keeps its value, whatever `key` does.
- R3: `ready` is 0 after any edge that samples `start`. A `start` during an expansion abandons it and restarts with the new key.
- R4: `ready` first reads 1 exactly 21 rising edges after the edge that samples `start`. It then stays 1 until the next `start`.
- R5: L is formed as follows. Let the four branches be B0..B3, with B0 taken from key bits 127:96, and let round r run from 0 to 11. In each round, B1 is XORed with F0(B0, CON[2r]) and B3 is XORed with F1(B2, CON[2r+1]). In every round except the last, the branches then rotate to (B1, B2, B3, B0). L is {B0, B1, B2, B3}. Table entry CON[n] sits at `CON_TABLE` bits [32n+31 : 32n].
- R6: F0 and F1 are defined as follows. T is the round key XORed with the input word, and byte 0 is the most significant byte. Each byte passes through an S-box. F0 uses the order SA, SB, SA, SB and F1 uses SB, SA, SB, SA. All arithmetic is in GF(2^8) modulo x^8+x^4+x^3+x^2+1. SA(x) is inv(x) XOR 0x63 and SB(x) is inv(x XOR 0xA5), with inv(0) = 0. Output byte i is the XOR over j of c[i XOR j]·S_j, where c = (1,2,4,6) for F0 and c = (1,8,2,0xA) for F1.
- R7: Iteration i runs from 0 to 8, and j runs from 0 to 3 with word 0 the most significant word of L. Round key number 4i+j is word j of L XOR CON[24+4i+j]. When i is odd, word j of the key is XORed in as well.
- R8: After every iteration, L becomes the permuted value formed by concatenating, with bit 0 as the most significant bit, L[7..63], L[121..127], L[0..6] and L[64..120].
- R9: `rk_out` is 0 whenever `rk_idx` is 36 or more.
- R10: `rk_out` shows the stored round key for `rk_idx` in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Capture `key` and begin expansion |
| key | input | 128 | Main key |
| rk_idx | input | 6 | Round key number to read |
| rk_out | output | 32 | Round key selected by `rk_idx` |
| wk | output | 128 | Four whitening words, word 0 in bits 127:96 |
| ready | output | 1 | All round keys stored |

## Verification
Every round key depends on L, and L passes through all twelve Feistel rounds. A single wrong S-box byte, matrix coefficient, constant index or branch rotation therefore corrupts essentially all 36 round keys. The same holds for a misplaced bit in the permutation, which spreads into all later iterations. Such faults show up on the first read-back after `ready`, 21 cycles after `start`. Faults in the odd-iteration key mixing or in the write addressing corrupt only particular groups of four indices. For that reason every index is read back and compared, and keys of all zeros and all ones are included so that missing XOR terms become visible. Control faults change the moment `ready` rises, or leave `wk` moving when it should hold, and are seen within a cycle.

// File: rtl/key_expander.sv
module key_expander (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [127:0] key,
  input  logic [5:0]   rk_idx,
  output logic [31:0]  rk_out,
  output logic [127:0] wk,
  output logic         ready
);
  parameter int LROUNDS = 12;
  parameter int ITERS = 9;
  localparam int NRK = 4 * ITERS;
  localparam int NCON = 2 * LROUNDS + NRK;
  localparam int CW = $clog2(LROUNDS > ITERS ? LROUNDS : ITERS);

  function automatic logic [32*NCON-1:0] make_con();
    logic [32*NCON-1:0] t;
    logic [31:0] x;
    t = '0;
    x = 32'hB7E15163;
    for (int n = 0; n < NCON; n++) begin
      x = x * 32'd1664525 + 32'd1013904223;
      t[32*n +: 32] = x ^ {x[15:0], x[31:16]};
    end
    return t;
  endfunction

  parameter logic [32*NCON-1:0] CON_TABLE = make_con();

  function automatic logic [31:0] con_at(input int n);
    return CON_TABLE[32*n +: 32];
  endfunction

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, aa;
    p = '0;
    aa = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p ^= aa;
      aa = {aa[6:0], 1'b0} ^ (aa[7] ? 8'h1D : 8'h00);
    end
    return p;
  endfunction

  function automatic logic [7:0] ginv(input logic [7:0] x);
    logic [7:0] r, p;
    r = 8'h01;
    p = x;
    for (int k = 1; k < 8; k++) begin
      p = gmul(p, p);
      r = gmul(r, p);
    end
    return r;
  endfunction

  function automatic logic [7:0] sbox(input logic sel, input logic [7:0] x);
    return sel ? ginv(x ^ 8'hA5) : (ginv(x) ^ 8'h63);
  endfunction

  function automatic logic [31:0] ffun(input logic which, input logic [31:0] rk, input logic [31:0] x);
    logic [31:0] t, y;
    logic [7:0] s [4];
    logic [7:0] c [4];
    t = rk ^ x;
    c = which ? '{8'h01, 8'h08, 8'h02, 8'h0A} : '{8'h01, 8'h02, 8'h04, 8'h06};
    for (int b = 0; b < 4; b++) s[b] = sbox(which ^ b[0], t[31-8*b -: 8]);
    y = '0;
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        y[31-8*i -: 8] ^= gmul(c[i ^ j], s[j]);
    return y;
  endfunction

  function automatic logic [127:0] dswap(input logic [127:0] x);
    return {x[120:64], x[6:0], x[127:121], x[63:7]};
  endfunction

  typedef enum logic [1:0] {IDLE, MIXL, EXPAND} st_t;

  st_t           state;
  logic [CW-1:0] cnt;
  logic [127:0]  lreg;
  logic [31:0]   rk_mem [NRK];
  logic [127:0]  gfn_nx;
  logic [31:0]   exp_w [4];
  logic [5:0]    wbase;

  always_comb begin
    logic [31:0] a1, a3;
    a1 = lreg[95:64] ^ ffun(1'b0, con_at(2*int'(cnt)),     lreg[127:96]);
    a3 = lreg[31:0]  ^ ffun(1'b1, con_at(2*int'(cnt) + 1), lreg[63:32]);
    if (cnt == CW'(LROUNDS - 1)) gfn_nx = {lreg[127:96], a1, lreg[63:32], a3};
    else                         gfn_nx = {a1, lreg[63:32], a3, lreg[127:96]};
  end

  always_comb
    for (int j = 0; j < 4; j++)
      exp_w[j] = lreg[127-32*j -: 32] ^ con_at(2*LROUNDS + 4*int'(cnt) + j)
               ^ (cnt[0] ? wk[127-32*j -: 32] : 32'h0);

  assign wbase  = 6'({cnt, 2'b00});
  assign rk_out = (rk_idx < 6'(NRK)) ? rk_mem[rk_idx] : 32'h0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= IDLE;
      cnt   <= '0;
      lreg  <= '0;
      wk    <= '0;
      ready <= 1'b0;
      for (int n = 0; n < NRK; n++) rk_mem[n] <= '0;
    end else if (start) begin
      wk    <= key;
      lreg  <= key;
      state <= MIXL;
      cnt   <= '0;
      ready <= 1'b0;
    end else begin
      case (state)
        MIXL: begin
          lreg <= gfn_nx;
          if (cnt == CW'(LROUNDS - 1)) begin
            state <= EXPAND;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        EXPAND: begin
          for (int j = 0; j < 4; j++) rk_mem[wbase + 6'(j)] <= exp_w[j];
          lreg <= dswap(lreg);
          if (cnt == CW'(ITERS - 1)) begin
            state <= IDLE;
            ready <= 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/key_expander_chk.sv
module key_expander_chk #(
  parameter int LAT = 21
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [127:0] key,
  input logic [5:0]   rk_idx,
  input logic [31:0]  rk_out,
  input logic [127:0] wk,
  input logic         ready
);
  logic [5:0] since;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) since <= '1;
    else if (start) since <= '0;
    else if (since != '1) since <= since + 1'b1;

  // R2
  wk_load_chk: assert property (@(posedge clk) disable iff (!rst_n) start |=> wk == $past(key));
  // R2
  wk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !start |=> $stable(wk));
  // R3
  ready_clear_chk: assert property (@(posedge clk) disable iff (!rst_n) start |=> !ready);
  // R4
  ready_latency_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(ready) |-> since == 6'(LAT));
  // R4
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) ready && !start |=> ready);
  // R9
  range_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) rk_idx >= 6'd36 |-> rk_out == 32'h0);
endmodule

bind key_expander key_expander_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .key(key),
  .rk_idx(rk_idx), .rk_out(rk_out), .wk(wk), .ready(ready)
);

// File: tb/key_expander_bench.sv
module key_expander_bench;
  localparam int NCON = 60;

  function automatic logic [32*NCON-1:0] bench_con();
    logic [32*NCON-1:0] t;
    for (int n = 0; n < NCON; n++)
      t[32*n +: 32] = {8'(n * 7 + 1), 8'(~n), 8'(n * 29 + 64), 8'(n ^ 150)};
    return t;
  endfunction

  localparam logic [32*NCON-1:0] TB_CON = bench_con();

  logic         clk = 0;
  logic         rst_n = 0;
  logic         start = 0;
  logic [127:0] key = '0;
  logic [5:0]   rk_idx = '0;
  logic [31:0]  rk_out;
  logic [127:0] wk;
  logic         ready;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q [$];
  event go;
  bit mon_done = 0;
  logic [7:0] sa_t [256];
  logic [7:0] sb_t [256];

  always #10 clk = ~clk;

  key_expander #(.CON_TABLE(TB_CON)) u_key_expander (
    .clk(clk), .rst_n(rst_n), .start(start), .key(key),
    .rk_idx(rk_idx), .rk_out(rk_out), .wk(wk), .ready(ready)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [7:0] rmul(input logic [7:0] a, input logic [7:0] b);
    logic [14:0] p;
    p = '0;
    for (int i = 0; i < 8; i++) if (b[i]) p ^= 15'(a) << i;
    for (int i = 14; i >= 8; i--) if (p[i]) p ^= 15'h11D << (i - 8);
    return p[7:0];
  endfunction

  function automatic logic [7:0] rinv(input logic [7:0] x);
    if (x == 0) return 8'h00;
    for (int y = 1; y < 256; y++) if (rmul(x, 8'(y)) == 8'h01) return 8'(y);
    return 8'h00;
  endfunction

  function automatic logic [31:0] cval(input int n);
    return TB_CON[32*n +: 32];
  endfunction

  // R6: F0 / F1 reference
  function automatic logic [31:0] rf(input bit which, input logic [31:0] rk, input logic [31:0] x);
    logic [31:0] t, y;
    logic [7:0] s [4];
    logic [7:0] m [4];
    t = rk ^ x;
    if (which) m = '{8'h01, 8'h08, 8'h02, 8'h0A};
    else       m = '{8'h01, 8'h02, 8'h04, 8'h06};
    for (int b = 0; b < 4; b++) begin
      logic [7:0] v;
      v = t[31-8*b -: 8];
      s[b] = ((b % 2 == 1) != which) ? sb_t[v] : sa_t[v];
    end
    y = '0;
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        y[31-8*i -: 8] ^= rmul(m[i ^ j], s[j]);
    return y;
  endfunction

  // R8: permutation written from the bit list, MSB-first numbering
  function automatic logic [127:0] rperm(input logic [127:0] v);
    logic [127:0] o;
    for (int p = 0; p < 128; p++) begin
      int src;
      if (p < 57)      src = 7 + p;
      else if (p < 64) src = 121 + (p - 57);
      else if (p < 71) src = p - 64;
      else             src = 64 + (p - 71);
      o[127-p] = v[127-src];
    end
    return o;
  endfunction

  // expected words follow R5, R6, R7 and R8
  task automatic push_expected(input logic [127:0] k);
    logic [31:0] b [4];
    logic [127:0] l;
    for (int j = 0; j < 4; j++) begin
      b[j] = k[127-32*j -: 32];
      exp_q.push_back(b[j]);
    end
    for (int r = 0; r < 12; r++) begin
      logic [31:0] t0;
      b[1] ^= rf(1'b0, cval(2*r), b[0]);
      b[3] ^= rf(1'b1, cval(2*r + 1), b[2]);
      if (r < 11) begin
        t0 = b[0]; b[0] = b[1]; b[1] = b[2]; b[2] = b[3]; b[3] = t0;
      end
    end
    l = {b[0], b[1], b[2], b[3]};
    for (int i = 0; i < 9; i++) begin
      for (int j = 0; j < 4; j++)
        exp_q.push_back(l[127-32*j -: 32] ^ cval(24 + 4*i + j) ^ ((i % 2 == 1) ? k[127-32*j -: 32] : 32'h0));
      l = rperm(l);
    end
  endtask

  task automatic run_key(input logic [127:0] k, input bit interrupt);
    int n;
    if (interrupt) begin
      @(negedge clk); key = ~k ^ 128'h5A; start = 1;
      @(negedge clk); start = 0;
      repeat (6) @(negedge clk);
      chk(ready == 0, "R3 busy", 128'(ready), 128'h0);
    end
    push_expected(k);
    @(negedge clk); key = k; start = 1;
    @(negedge clk); start = 0; n = 1;
    chk(ready == 0, "R3 clear", 128'(ready), 128'h0);
    while (!ready && n < 100) begin @(negedge clk); n++; end
    // R4: 21 edges after the start edge, observed after the 22nd edge counted inclusively
    chk(n == 22, "R4 latency", 128'(n), 128'd22);
    ->go;
    wait (mon_done);
    mon_done = 0;
    chk(exp_q.size() == 0, "R7 queue drained", 128'(exp_q.size()), 128'h0);
  endtask

  initial begin : monitor
    forever begin
      @go;
      for (int i = 0; i < 4; i++) begin
        logic [31:0] e;
        e = exp_q.pop_front();
        chk(wk[127-32*i -: 32] == e, "R2 whitening", 128'(wk[127-32*i -: 32]), 128'(e));
      end
      for (int idx = 0; idx < 36; idx++) begin
        logic [31:0] e;
        rk_idx = 6'(idx);
        #1;
        e = exp_q.pop_front();
        // R10: read without an intervening edge
        chk(rk_out == e, "R7 round key", 128'(rk_out), 128'(e));
      end
      mon_done = 1;
    end
  end

  initial begin : watchdog
    #4000000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : driver
    logic [127:0] wk_snap;
    logic [31:0] rk_snap;
    for (int x = 0; x < 256; x++) begin
      sa_t[x] = rinv(8'(x)) ^ 8'h63;
      sb_t[x] = rinv(8'(x) ^ 8'hA5);
    end
    repeat (3) @(negedge clk);
    // R1
    chk(ready == 0, "R1 ready", 128'(ready), 128'h0);
    chk(wk == 0, "R1 wk", wk, 128'h0);
    rk_idx = 6'd0;  #1 chk(rk_out == 0, "R1 rk0", 128'(rk_out), 128'h0);
    rk_idx = 6'd35; #1 chk(rk_out == 0, "R1 rk35", 128'(rk_out), 128'h0);
    rst_n = 1;

    run_key(128'h0, 0);
    run_key({128{1'b1}}, 0);
    run_key(128'h0123456789ABCDEF_FEDCBA9876543210, 0);
    run_key(128'h80000000_00000000_00000000_00000001, 1);

    // R9
    @(negedge clk);
    rk_idx = 6'd36; #1 chk(rk_out == 0, "R9 idx36", 128'(rk_out), 128'h0);
    rk_idx = 6'd50; #1 chk(rk_out == 0, "R9 idx50", 128'(rk_out), 128'h0);
    rk_idx = 6'd63; #1 chk(rk_out == 0, "R9 idx63", 128'(rk_out), 128'h0);

    // R2: key moves without start, outputs hold
    rk_idx = 6'd17; #1;
    wk_snap = wk; rk_snap = rk_out;
    key = 128'hDEADBEEF_00000000_CAFEF00D_11111111;
    repeat (5) @(negedge clk);
    chk(wk == wk_snap, "R2 hold", wk, wk_snap);
    chk(rk_out == rk_snap, "R2 rk hold", 128'(rk_out), 128'(rk_snap));
    chk(ready == 1, "R4 ready stays", 128'(ready), 128'h1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule